// File: doc/BRIEF.md
# Byte-Wide Video Memory Access Port

This block lets an 8-bit processor reach a memory organised as 16-bit words. The processor loads a word address one byte at a time, then writes or reads the two halves of each word through separate byte registers. A control byte picks which of the two byte lanes advances the address after an access, how far the address moves, and an optional rotation of the low address bits. The rotation lets tiled graphics be written in a linear order and still land in the memory's interleaved layout.

Reads use a one-word prefetch buffer. Loading either address byte, or any access that advances the address, starts a fetch of the addressed word into the buffer. The two read registers then return the buffered bytes. A small state machine orders the memory traffic. It has four states: IDLE accepts processor accesses. WRITE drives one byte-lane write. READ issues a memory read. LOAD captures the returned word. Its transitions are as follows. IDLE goes to WRITE on a data write. IDLE goes to READ on an address-byte write or on a read that advances the address. WRITE goes to READ if that write advanced the address, and to IDLE otherwise. READ always goes to LOAD, and LOAD always returns to IDLE.

Top module: `vmem_port`

## Requirements
- R1: After reset the control byte, the address and the read buffer are zero, the state is IDLE, and neither `mem_we` nor `mem_re` is active.
- R2: Register select codes are 0 control, 1 address low, 2 address high, 3 write low, 4 write high, 5 read low and 6 read high. Control bit 7 selects the advancing lane, bits 3:2 hold the remap code and bits 1:0 the step code. A control readback returns bits 6:4 as zero, and unused selects read zero.
- R3: An accepted write to select 3 gives, one cycle later, a single cycle with `mem_we`=01 and the byte on `mem_wdata[7:0]`. A write to select 4 gives `mem_we`=10 with the byte on `mem_wdata[15:8]`. Both go to the mapped address held before the write.
- R4: With control bit 7 at 0, only select 3 writes and select 5 reads advance the address. With bit 7 at 1, only select 4 writes and select 6 reads advance it.
- R5: Step code 0 adds 1, code 1 adds 32, and codes 2 and 3 add 128. The 15-bit address wraps from 0x7FFF to zero.
- R6: A remap code c from 1 to 3 rotates the low 7+c bits of the address left by 3 on the memory side. The stored address is unchanged.
- R7: Writing either address byte, or an access that advances the address, fetches the word at the new mapped address. The fetch is one `mem_re` cycle, issued after any pending byte write. Reads of selects 5 and 6 then return the low and high bytes of that word.
- R8: A read of the non-advancing read byte neither moves the address nor touches the buffer or memory.
- R9: Any processor access made while the state is not IDLE is ignored: no register, address or memory change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 3 | Register select |
| cpu_wr | input | 1 | Write strobe, one cycle |
| cpu_rd | input | 1 | Read strobe, one cycle |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte for the current select |
| mem_addr | output | 15 | Word address to memory |
| mem_we | output | 2 | Byte-lane write enables |
| mem_wdata | output | 16 | Write word; the byte appears on both lanes |
| mem_re | output | 1 | Read request; data is expected one cycle later |
| mem_rdata | input | 16 | Read word from memory |

## Verification
The bench builds the port with its default parameters: a 15-bit address and steps of 32 and 128. This makes the wrap from 0x7FFF reachable with a single write, and all three rotation widths fit inside the address. The low-lane-advance and high-lane-advance settings are both exercised with writes and reads. A back-to-back access issued during the WRITE state shows whether the busy gate holds.

// File: rtl/vmp_pkg.sv
package vmp_pkg;

    typedef enum logic [2:0] {
        SEL_CTRL    = 3'd0,
        SEL_ADDR_LO = 3'd1,
        SEL_ADDR_HI = 3'd2,
        SEL_WR_LO   = 3'd3,
        SEL_WR_HI   = 3'd4,
        SEL_RD_LO   = 3'd5,
        SEL_RD_HI   = 3'd6,
        SEL_SPARE   = 3'd7
    } sel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2,
        ST_LOAD  = 2'd3
    } state_e;

    typedef struct packed {
        logic       inc_hi;
        logic [1:0] remap;
        logic [1:0] step;
    } ctrl_t;

endpackage

// File: rtl/vmp_addr_unit.sv
module vmp_addr_unit #(
    parameter int ADDR_W   = 15,
    parameter int STEP_MID = 32,
    parameter int STEP_BIG = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic              inc_en,
    input  logic [7:0]        byte_in,
    input  logic [1:0]        step_code,
    input  logic [1:0]        remap_code,
    output logic [ADDR_W-1:0] addr_o,
    output logic [ADDR_W-1:0] maddr_o
);
    localparam int HI_W     = ADDR_W - 8;
    localparam int GRP_BASE = 7;
    localparam int ROT      = 3;
    localparam int IDX_W    = $clog2(ADDR_W);

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] step_v;

    if (HI_W < 8) begin : g_pad
        wire unused_pad = ^byte_in[7:HI_W];
    end

    always_comb begin
        unique case (step_code)
            2'd0:    step_v = ADDR_W'(1);
            2'd1:    step_v = ADDR_W'(STEP_MID);
            default: step_v = ADDR_W'(STEP_BIG);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (ld_lo) begin
            addr_q[7:0] <= byte_in;
        end else if (ld_hi) begin
            addr_q[ADDR_W-1:8] <= byte_in[HI_W-1:0];
        end else if (inc_en) begin
            addr_q <= addr_q + step_v;
        end
    end

    function automatic logic [ADDR_W-1:0] rot_low(input logic [ADDR_W-1:0] a, input int n);
        logic [ADDR_W-1:0] r;
        logic [IDX_W-1:0]  idx;
        r = a;
        for (int i = 0; i < ADDR_W; i++) begin
            if (i < n) begin
                idx  = IDX_W'((i + n - ROT) % n);
                r[i] = a[idx];
            end
        end
        return r;
    endfunction

    always_comb begin
        if (remap_code == 2'd0) maddr_o = addr_q;
        else                    maddr_o = rot_low(addr_q, GRP_BASE + int'(remap_code));
    end

    assign addr_o = addr_q;

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_lo || ld_hi || inc_en) |=> $stable(addr_q)); // R4
    AST_MAP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (remap_code == 2'd0) |-> (maddr_o == addr_o)); // R6

endmodule

// File: rtl/vmp_fsm.sv
module vmp_fsm
    import vmp_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   go_write,
    input  logic   go_fetch,
    input  logic   fetch_after,
    output state_e state,
    output logic   idle,
    output logic   rd_req,
    output logic   wr_phase,
    output logic   load
);
    state_e state_q, state_d;
    logic   pend_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go_write)      state_d = ST_WRITE;
                else if (go_fetch) state_d = ST_READ;
            end
            ST_WRITE: state_d = pend_q ? ST_READ : ST_IDLE;
            ST_READ:  state_d = ST_LOAD;
            ST_LOAD:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && go_write) pend_q <= fetch_after;
        end
    end

    always_comb begin
        idle     = 1'b0;
        rd_req   = 1'b0;
        wr_phase = 1'b0;
        load     = 1'b0;
        unique case (state_q)
            ST_IDLE:  idle     = 1'b1;
            ST_WRITE: wr_phase = 1'b1;
            ST_READ:  rd_req   = 1'b1;
            ST_LOAD:  load     = 1'b1;
            default:  idle     = 1'b0;
        endcase
    end

    assign state = state_q;

    AST_READ_THEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ) |=> (state_q == ST_LOAD)); // R7
    AST_LOAD_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD) |=> (state_q == ST_IDLE)); // R7

endmodule

// File: rtl/vmp_rdbuf.sv
module vmp_rdbuf (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [15:0] word_in,
    output logic [15:0] word_o
);
    logic [15:0] buf_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    buf_q <= '0;
        else if (load) buf_q <= word_in;
    end

    assign word_o = buf_q;

    AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(buf_q)); // R8

endmodule

// File: rtl/vmem_port.sv
module vmem_port
    import vmp_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter int STEP_MID = 32,
    parameter int STEP_BIG = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cpu_sel,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_we,
    output logic [15:0]       mem_wdata,
    output logic              mem_re,
    input  logic [15:0]       mem_rdata
);
    sel_e   sel;
    ctrl_t  ctrl;
    state_e state;
    logic   idle, rd_req, wr_phase, load;
    logic   acc_wr, acc_rd;
    logic   ld_lo, ld_hi, dat_wr, trig_wr, trig_rd, inc_en;
    logic [ADDR_W-1:0] addr, maddr, wr_addr;
    logic [1:0]  wr_lane;
    logic [7:0]  wr_byte;
    logic [15:0] rbuf;

    assign sel    = sel_e'(cpu_sel);
    assign acc_wr = idle & cpu_wr;
    assign acc_rd = idle & cpu_rd & ~cpu_wr;

    assign ld_lo   = acc_wr & (sel == SEL_ADDR_LO);
    assign ld_hi   = acc_wr & (sel == SEL_ADDR_HI);
    assign dat_wr  = acc_wr & ((sel == SEL_WR_LO) | (sel == SEL_WR_HI));
    assign trig_wr = acc_wr & (sel == (ctrl.inc_hi ? SEL_WR_HI : SEL_WR_LO));
    assign trig_rd = acc_rd & (sel == (ctrl.inc_hi ? SEL_RD_HI : SEL_RD_LO));
    assign inc_en  = trig_wr | trig_rd;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (acc_wr && sel == SEL_CTRL) begin
            ctrl.inc_hi <= cpu_wdata[7];
            ctrl.remap  <= cpu_wdata[3:2];
            ctrl.step   <= cpu_wdata[1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_addr <= '0;
            wr_lane <= 2'b00;
            wr_byte <= 8'h00;
        end else if (dat_wr) begin
            wr_addr <= maddr;
            wr_lane <= (sel == SEL_WR_HI) ? 2'b10 : 2'b01;
            wr_byte <= cpu_wdata;
        end
    end

    vmp_addr_unit #(
        .ADDR_W   (ADDR_W),
        .STEP_MID (STEP_MID),
        .STEP_BIG (STEP_BIG)
    ) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_lo      (ld_lo),
        .ld_hi      (ld_hi),
        .inc_en     (inc_en),
        .byte_in    (cpu_wdata),
        .step_code  (ctrl.step),
        .remap_code (ctrl.remap),
        .addr_o     (addr),
        .maddr_o    (maddr)
    );

    vmp_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_write    (dat_wr),
        .go_fetch    (ld_lo | ld_hi | trig_rd),
        .fetch_after (trig_wr),
        .state       (state),
        .idle        (idle),
        .rd_req      (rd_req),
        .wr_phase    (wr_phase),
        .load        (load)
    );

    vmp_rdbuf u_rbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .word_in (mem_rdata),
        .word_o  (rbuf)
    );

    assign mem_addr  = wr_phase ? wr_addr : maddr;
    assign mem_we    = wr_phase ? wr_lane : 2'b00;
    assign mem_wdata = {wr_byte, wr_byte};
    assign mem_re    = rd_req;

    always_comb begin
        unique case (sel)
            SEL_CTRL:  cpu_rdata = {ctrl.inc_hi, 3'b000, ctrl.remap, ctrl.step};
            SEL_RD_LO: cpu_rdata = rbuf[7:0];
            SEL_RD_HI: cpu_rdata = rbuf[15:8];
            default:   cpu_rdata = 8'h00;
        endcase
    end

    AST_LANE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mem_we) <= 1); // R3
    AST_LO_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && sel == SEL_WR_LO) |=> (mem_we == 2'b01)); // R3
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && (mem_we != 2'b00))); // R7
    AST_CTRL_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_CTRL) |-> (cpu_rdata[6:4] == 3'b000)); // R2
    AST_BUSY_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && cpu_wr) |=> $stable(ctrl)); // R9
    AST_BUSY_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(addr)); // R9

endmodule

// File: tb/vmem_port_tb.sv
`timescale 1ns/1ps
module vmem_port_tb;
    import vmp_pkg::*;

    localparam int AW = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [2:0]  cpu_sel = 3'd0;
    logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [7:0]  cpu_wdata = 8'h00;
    wire  [7:0]  cpu_rdata;
    wire  [AW-1:0] mem_addr;
    wire  [1:0]  mem_we;
    wire  [15:0] mem_wdata;
    wire         mem_re;
    logic [15:0] mem_rdata = 16'h0000;

    vmem_port u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_re(mem_re), .mem_rdata(mem_rdata)
    );

    typedef struct {
        bit          is_wr;
        int          addr;
        logic [1:0]  we;
        logic [7:0]  data;
        string       req;
    } item_t;

    item_t q[$];
    item_t mon_e;
    int checks = 0, errors = 0;
    logic [15:0] bmem [int];
    logic [15:0] exp_buf = 16'h0000;
    int m_addr = 0, m_remap = 0, m_step = 0;
    bit m_hi = 1'b0;

    function automatic logic [15:0] mpeek(int a);
        if (bmem.exists(a)) return bmem[a];
        return 16'(a * 40503) ^ 16'h5A5A;
    endfunction

    function automatic int b_map(int a, int code);
        int n, mask, low, rot;
        if (code == 0) return a;
        n = code + 7;
        mask = (1 << n) - 1;
        low = a & mask;
        rot = ((low << 3) | (low >> (n - 3))) & mask;
        return (a & ~mask) | rot;
    endfunction

    function automatic int b_step(int code);
        if (code == 0) return 1;
        if (code == 1) return 32;
        return 128;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(bit w, int a, logic [1:0] we, logic [7:0] d, string r);
        item_t e;
        e.is_wr = w; e.addr = a; e.we = we; e.data = d; e.req = r;
        q.push_back(e);
    endtask

    // memory model, one-cycle read latency
    always @(posedge clk) begin
        logic [15:0] t;
        if (mem_re) mem_rdata <= mpeek(int'(mem_addr));
        if (mem_we != 2'b00) begin
            t = mpeek(int'(mem_addr));
            if (mem_we[0]) t[7:0]  = mem_wdata[7:0];
            if (mem_we[1]) t[15:8] = mem_wdata[15:8];
            bmem[int'(mem_addr)] = t;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && (mem_we != 2'b00 || mem_re)) begin
            if (q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R9 unexpected memory cycle actual we=%0b re=%0b addr=%0h expected none",
                         mem_we, mem_re, mem_addr);
            end else begin
                mon_e = q.pop_front();
                if (mon_e.is_wr) begin
                    check(mon_e.req, "write addr", int'(mem_addr), mon_e.addr);
                    check(mon_e.req, "write lane", int'(mem_we), int'(mon_e.we));
                    check(mon_e.req, "write byte",
                          int'(mon_e.we[1] ? mem_wdata[15:8] : mem_wdata[7:0]), int'(mon_e.data));
                end else begin
                    check(mon_e.req, "fetch addr", int'(mem_addr), mon_e.addr);
                    check(mon_e.req, "fetch strobe", int'({mem_re, mem_we}), 4);
                    exp_buf = mpeek(mon_e.addr);
                end
            end
        end
    end

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic cpu_write(sel_e sel, logic [7:0] d, string req);
        unique case (sel)
            SEL_CTRL: begin m_hi = d[7]; m_remap = int'(d[3:2]); m_step = int'(d[1:0]); end
            SEL_ADDR_LO: begin
                m_addr = (m_addr & 32'h7F00) | int'(d);
                push(1'b0, b_map(m_addr, m_remap), 2'b00, 8'h00, req);
            end
            SEL_ADDR_HI: begin
                m_addr = (m_addr & 32'hFF) | ((int'(d) & 32'h7F) << 8);
                push(1'b0, b_map(m_addr, m_remap), 2'b00, 8'h00, req);
            end
            SEL_WR_LO, SEL_WR_HI: begin
                push(1'b1, b_map(m_addr, m_remap), (sel == SEL_WR_HI) ? 2'b10 : 2'b01, d, req);
                if ((sel == SEL_WR_HI) == m_hi) begin
                    m_addr = (m_addr + b_step(m_step)) & 32'h7FFF;
                    push(1'b0, b_map(m_addr, m_remap), 2'b00, 8'h00, req);
                end
            end
            default: ;
        endcase
        @(negedge clk);
        cpu_sel = sel; cpu_wr = 1'b1; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
        settle();
    endtask

    task automatic peek(sel_e sel, logic [7:0] exp, string req);
        @(negedge clk);
        cpu_sel = sel;
        #1;
        check(req, "read byte", int'(cpu_rdata), int'(exp));
    endtask

    task automatic cpu_read(sel_e sel, string req);
        logic [7:0] exp;
        exp = (sel == SEL_RD_HI) ? exp_buf[15:8] : exp_buf[7:0];
        @(negedge clk);
        cpu_sel = sel; cpu_rd = 1'b1;
        #1;
        check(req, "read port", int'(cpu_rdata), int'(exp));
        if ((sel == SEL_RD_HI) == m_hi) begin
            m_addr = (m_addr + b_step(m_step)) & 32'h7FFF;
            push(1'b0, b_map(m_addr, m_remap), 2'b00, 8'h00, req);
        end
        @(negedge clk);
        cpu_rd = 1'b0;
        settle();
    endtask

    task automatic set_addr(int a, string req);
        cpu_write(SEL_ADDR_LO, 8'(a), req);
        cpu_write(SEL_ADDR_HI, 8'(a >> 8), req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] before_hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        peek(SEL_CTRL, 8'h00, "R1");
        peek(SEL_RD_LO, 8'h00, "R1");
        peek(SEL_RD_HI, 8'h00, "R1");
        check("R1", "strobes", int'({mem_re, mem_we}), 0);

        // R2 control readback with padding
        cpu_write(SEL_CTRL, 8'hFF, "R2");
        peek(SEL_CTRL, 8'h8F, "R2");
        peek(SEL_SPARE, 8'h00, "R2");
        cpu_write(SEL_CTRL, 8'h00, "R2");
        peek(SEL_CTRL, 8'h00, "R2");

        // R7 address writes prefetch
        set_addr(32'h1234, "R7");
        peek(SEL_RD_LO, exp_buf[7:0], "R7");
        peek(SEL_RD_HI, exp_buf[15:8], "R7");

        // R3 / R4 lane writes with low-lane advance
        cpu_write(SEL_WR_LO, 8'hAB, "R3");
        cpu_write(SEL_WR_HI, 8'hCD, "R4");

        // R8 reads: non-advancing byte first, then advancing byte
        cpu_write(SEL_ADDR_LO, 8'h34, "R7");
        cpu_read(SEL_RD_HI, "R8");
        cpu_read(SEL_RD_LO, "R8");
        peek(SEL_RD_HI, 8'hCD, "R8");
        check("R8", "model addr", m_addr, 32'h1235);

        // R4 high-lane advance
        cpu_write(SEL_CTRL, 8'h80, "R4");
        cpu_write(SEL_WR_LO, 8'h11, "R4");
        cpu_write(SEL_WR_HI, 8'h22, "R4");
        cpu_read(SEL_RD_LO, "R4");
        cpu_read(SEL_RD_HI, "R4");

        // R5 step sizes
        cpu_write(SEL_CTRL, 8'h01, "R5");
        cpu_write(SEL_WR_LO, 8'h31, "R5");
        cpu_write(SEL_WR_LO, 8'h32, "R5");
        cpu_write(SEL_CTRL, 8'h02, "R5");
        cpu_write(SEL_WR_LO, 8'h33, "R5");
        cpu_write(SEL_CTRL, 8'h03, "R5");
        cpu_write(SEL_WR_LO, 8'h34, "R5");

        // R5 wrap at the top of the address space
        cpu_write(SEL_CTRL, 8'h00, "R5");
        set_addr(32'h7FFF, "R5");
        cpu_write(SEL_WR_LO, 8'h5A, "R5");
        check("R5", "wrap addr", m_addr, 0);

        // R6 remap widths
        cpu_write(SEL_CTRL, 8'h04, "R6");
        set_addr(32'h0ABC, "R6");
        cpu_write(SEL_WR_LO, 8'h61, "R6");
        cpu_write(SEL_CTRL, 8'h08, "R6");
        cpu_write(SEL_WR_LO, 8'h62, "R6");
        cpu_write(SEL_CTRL, 8'h0C, "R6");
        cpu_write(SEL_WR_LO, 8'h63, "R6");
        cpu_read(SEL_RD_LO, "R6");
        check("R6", "rotation sample", b_map(32'h0ABC, 1), 32'h0AE5);

        // R9 access during WRITE state ignored
        cpu_write(SEL_CTRL, 8'h00, "R9");
        set_addr(32'h0200, "R9");
        before_hi = exp_buf[15:8];
        push(1'b1, 32'h0200, 2'b01, 8'h5E, "R9");
        m_addr = 32'h0201;
        push(1'b0, 32'h0201, 2'b00, 8'h00, "R9");
        @(negedge clk);
        cpu_sel = SEL_WR_LO; cpu_wr = 1'b1; cpu_wdata = 8'h5E;
        @(negedge clk);
        cpu_sel = SEL_WR_HI; cpu_wdata = 8'h77;
        @(negedge clk);
        cpu_wr = 1'b0;
        settle();
        set_addr(32'h0200, "R9");
        peek(SEL_RD_HI, before_hi, "R9");
        peek(SEL_RD_LO, 8'h5E, "R3");

        settle();
        check("R7", "pending expectations", q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule